// File: doc/BRIEF.md
# Keyed Index/Data Configuration Register Block

This block holds the setup registers of a multi-function I/O controller. A host reaches it through two byte-wide ports that share one address bit: a pointer port (address 0) and a value port (address 1). The block starts locked. While it is locked, the value port reads as 0xFF and writes to it are dropped.

Writing the unlock byte 0x55 to the pointer port opens the register space. While open, each byte written to the pointer port selects a register index, and the value port then reads or writes that register. Writing 0xAA to the pointer port closes the space again.

Some registers are shared by the whole chip: the device selector, the identifier, the revision and five general setup bytes. The rest form one bank per function. The device selector picks which bank is seen at the banked indices. Four functions are built in, at device numbers 0x00, 0x04, 0x05 and 0x07. Each function drives its enable bit, its 16-bit base address and its primary interrupt number straight out of the block.

The read byte is combinational: `host_rdata` always shows the register that `host_addr` and the current index point to. Reads have no side effects.

Top module: `cfgp_top`

## Requirements
- R1: After a synchronous reset the block is locked. The device selector is 0 and all enable bits are 0. The interrupt outputs are 0. The bases are 0x03F0, 0x03F8, 0x02F8 and 0x0060 for device numbers 0x00, 0x04, 0x05 and 0x07.
- R2: While locked, the value port reads 0xFF and writes to it are ignored. The pointer port also reads 0xFF, and every pointer write other than 0x55 is ignored.
- R3: Writing 0x55 to the pointer port while locked opens the space. While open, a pointer write selects the index, and reading the pointer port returns that index.
- R4: Index 0x20 reads the identifier 0x4D and index 0x21 reads the revision (default 0x01). Writes to either index leave the value unchanged.
- R5: Index 0x07 holds the device selector. Writes to banked indices change only the bank whose device number equals the selector.
- R6: In the selected bank, index 0x60 holds bits 15:8 of the base and index 0x61 holds bits 7:0. Index 0x70 holds the primary interrupt. All three drive the outputs for that device.
- R7: Global indices 0x22, 0x23, 0x24, 0x26 and 0x27 are read/write and are not banked: they read the same under any selector value.
- R8: A selector naming a device that does not exist, or any unimplemented index, reads 0x00 and discards writes.
- R9: Writing 0xAA to the pointer port closes the space only while it is open. Writing 0xAA while locked changes nothing.
- R10: Index 0x30 stores only bit 0 as the device enable; bits 7:1 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_addr | input | 1 | 0 = pointer port, 1 = value port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte for the addressed port |
| dev_active | output | 4 | Enable per device, slot 0..3 = device 0x00, 0x04, 0x05, 0x07 |
| dev_base | output | 64 | Base address per device, slot s at bits 16s+15:16s |
| dev_irq | output | 32 | Primary interrupt per device, slot s at bits 8s+7:8s |

## Verification
The properties check the following on every cycle:
- the lock machine's entry and exit rules, and that it stays locked without the key;
- the 0xFF read-back on the value port while locked;
- that no bank or global register moves without a qualifying write;
- that at most one bank claims a read.

Only the bench scenarios can show the rest:
- whole sequences such as selecting a device and then writing its base;
- that a bank is isolated from the other devices;
- the identifier and revision values themselves;
- that an exit key sent while locked does no harm.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int NUM_DEV = 4;
    localparam int BW      = 8;
    localparam int AW      = 16;

    localparam logic [BW-1:0] KEY_OPEN  = 8'h55;
    localparam logic [BW-1:0] KEY_CLOSE = 8'hAA;

    localparam logic [BW-1:0] IX_SEL   = 8'h07;
    localparam logic [BW-1:0] IX_IDENT = 8'h20;
    localparam logic [BW-1:0] IX_REV   = 8'h21;
    localparam logic [BW-1:0] IX_PWR   = 8'h22;
    localparam logic [BW-1:0] IX_PMG   = 8'h23;
    localparam logic [BW-1:0] IX_OSC   = 8'h24;
    localparam logic [BW-1:0] IX_PADR0 = 8'h26;
    localparam logic [BW-1:0] IX_PADR1 = 8'h27;

    localparam logic [BW-1:0] IX_EN    = 8'h30;
    localparam logic [BW-1:0] IX_BHI   = 8'h60;
    localparam logic [BW-1:0] IX_BLO   = 8'h61;
    localparam logic [BW-1:0] IX_IRQA  = 8'h70;
    localparam logic [BW-1:0] IX_IRQB  = 8'h72;
    localparam logic [BW-1:0] IX_MODE  = 8'hF0;

    typedef enum logic {ST_LOCKED = 1'b0, ST_OPEN = 1'b1} lock_st_t;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] base;
        logic [BW-1:0] irq_a;
        logic [BW-1:0] irq_b;
        logic [BW-1:0] mode;
    } bank_t;

    typedef struct packed {
        logic [BW-1:0] pwr;
        logic [BW-1:0] pmg;
        logic [BW-1:0] osc;
        logic [BW-1:0] padr0;
        logic [BW-1:0] padr1;
    } glob_t;

    function automatic logic [BW-1:0] slot_dev_num(input int s);
        case (s)
            0:       return 8'h00;
            1:       return 8'h04;
            2:       return 8'h05;
            default: return 8'h07;
        endcase
    endfunction

    function automatic logic [AW-1:0] slot_def_base(input int s);
        case (s)
            0:       return 16'h03F0;
            1:       return 16'h03F8;
            2:       return 16'h02F8;
            default: return 16'h0060;
        endcase
    endfunction

    function automatic logic is_bank_ix(input logic [BW-1:0] ix);
        return (ix == IX_EN) || (ix == IX_BHI) || (ix == IX_BLO) ||
               (ix == IX_IRQA) || (ix == IX_IRQB) || (ix == IX_MODE);
    endfunction

endpackage

// File: rtl/cfgp_lock.sv
module cfgp_lock
    import cfgp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ptr_wr,
    input  logic [BW-1:0] wdata,
    output logic          is_open,
    output logic [BW-1:0] index
);
    lock_st_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_LOCKED;
            index <= '0;
        end else if (ptr_wr) begin
            if (st_q == ST_LOCKED) begin
                if (wdata == KEY_OPEN) st_q <= ST_OPEN;
            end else if (wdata == KEY_CLOSE) begin
                st_q <= ST_LOCKED;
            end else begin
                index <= wdata;
            end
        end
    end

    assign is_open = (st_q == ST_OPEN);

    a_r3_key_opens: assert property (@(posedge clk) disable iff (rst)
        (!is_open && ptr_wr && wdata == KEY_OPEN) |=> is_open);
    a_r2_stays_locked: assert property (@(posedge clk) disable iff (rst)
        (!is_open && !(ptr_wr && wdata == KEY_OPEN)) |=> !is_open);
    a_r9_key_closes: assert property (@(posedge clk) disable iff (rst)
        (is_open && ptr_wr && wdata == KEY_CLOSE) |=> !is_open);
    a_r2_index_held_locked: assert property (@(posedge clk) disable iff (rst)
        !is_open |=> $stable(index));

endmodule

// File: rtl/cfgp_globals.sv
module cfgp_globals
    import cfgp_pkg::*;
#(
    parameter logic [BW-1:0] CHIP_ID  = 8'h4D,
    parameter logic [BW-1:0] CHIP_REV = 8'h01
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [BW-1:0] index,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] sel,
    output logic          rd_hit,
    output logic [BW-1:0] rd_val
);
    glob_t g_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
            g_q <= '0;
        end else if (wr_stb) begin
            case (index)
                IX_SEL:   sel     <= wdata;
                IX_PWR:   g_q.pwr   <= wdata;
                IX_PMG:   g_q.pmg   <= wdata;
                IX_OSC:   g_q.osc   <= wdata;
                IX_PADR0: g_q.padr0 <= wdata;
                IX_PADR1: g_q.padr1 <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_hit = 1'b1;
        case (index)
            IX_SEL:   rd_val = sel;
            IX_IDENT: rd_val = CHIP_ID;
            IX_REV:   rd_val = CHIP_REV;
            IX_PWR:   rd_val = g_q.pwr;
            IX_PMG:   rd_val = g_q.pmg;
            IX_OSC:   rd_val = g_q.osc;
            IX_PADR0: rd_val = g_q.padr0;
            IX_PADR1: rd_val = g_q.padr1;
            default: begin
                rd_hit = 1'b0;
                rd_val = '0;
            end
        endcase
    end

    a_r7_globals_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> ($stable(g_q) && $stable(sel)));

endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
    import cfgp_pkg::*;
#(
    parameter int SLOT = 0
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [BW-1:0] sel,
    input  logic [BW-1:0] index,
    input  logic [BW-1:0] wdata,
    output bank_t         regs,
    output logic          rd_hit,
    output logic [BW-1:0] rd_val
);
    localparam logic [BW-1:0] MY_NUM = slot_dev_num(SLOT);
    localparam logic [AW-1:0] MY_DEF = slot_def_base(SLOT);

    logic picked;
    assign picked = (sel == MY_NUM);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs      <= '0;
            regs.base <= MY_DEF;
        end else if (wr_stb && picked) begin
            case (index)
                IX_EN:   regs.en          <= wdata[0];
                IX_BHI:  regs.base[15:8]  <= wdata;
                IX_BLO:  regs.base[7:0]   <= wdata;
                IX_IRQA: regs.irq_a       <= wdata;
                IX_IRQB: regs.irq_b       <= wdata;
                IX_MODE: regs.mode        <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_hit = picked && is_bank_ix(index);
        case (index)
            IX_EN:   rd_val = {7'b0, regs.en};
            IX_BHI:  rd_val = regs.base[15:8];
            IX_BLO:  rd_val = regs.base[7:0];
            IX_IRQA: rd_val = regs.irq_a;
            IX_IRQB: rd_val = regs.irq_b;
            IX_MODE: rd_val = regs.mode;
            default: rd_val = '0;
        endcase
    end

    a_r5_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && sel == MY_NUM) |=> $stable(regs));

endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter logic [7:0] CHIP_ID  = 8'h4D,
    parameter logic [7:0] CHIP_REV = 8'h01
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr,
    input  logic                  host_addr,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    output logic [NUM_DEV-1:0]    dev_active,
    output logic [NUM_DEV*AW-1:0] dev_base,
    output logic [NUM_DEV*BW-1:0] dev_irq
);
    logic          is_open;
    logic [BW-1:0] index;
    logic [BW-1:0] sel;
    logic          g_hit;
    logic [BW-1:0] g_val;
    logic          data_wr;

    logic [NUM_DEV-1:0] b_hit;
    logic [BW-1:0]      b_val [NUM_DEV];
    bank_t              b_regs [NUM_DEV];

    assign data_wr = host_wr && host_addr && is_open;

    cfgp_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .ptr_wr  (host_wr && !host_addr),
        .wdata   (host_wdata),
        .is_open (is_open),
        .index   (index)
    );

    cfgp_globals #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_glob (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (data_wr),
        .index  (index),
        .wdata  (host_wdata),
        .sel    (sel),
        .rd_hit (g_hit),
        .rd_val (g_val)
    );

    for (genvar s = 0; s < NUM_DEV; s++) begin : g_bank
        cfgp_bank #(.SLOT(s)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_stb (data_wr),
            .sel    (sel),
            .index  (index),
            .wdata  (host_wdata),
            .regs   (b_regs[s]),
            .rd_hit (b_hit[s]),
            .rd_val (b_val[s])
        );
        assign dev_active[s]         = b_regs[s].en;
        assign dev_base[s*AW +: AW]  = b_regs[s].base;
        assign dev_irq[s*BW +: BW]   = b_regs[s].irq_a;
    end

    logic [BW-1:0] bank_rd;
    always_comb begin
        bank_rd = '0;
        for (int s = 0; s < NUM_DEV; s++) begin
            if (b_hit[s]) bank_rd = bank_rd | b_val[s];
        end
    end

    always_comb begin
        if (!is_open)        host_rdata = 8'hFF;
        else if (!host_addr) host_rdata = index;
        else if (g_hit)      host_rdata = g_val;
        else                 host_rdata = bank_rd;
    end

    a_r2_locked_reads_ff: assert property (@(posedge clk) disable iff (rst)
        !is_open |-> host_rdata == 8'hFF);
    a_r8_one_bank_claims: assert property (@(posedge clk) disable iff (rst)
        $onehot0(b_hit));
    a_r2_outputs_hold_locked: assert property (@(posedge clk) disable iff (rst)
        !is_open |=> ($stable(dev_active) && $stable(dev_base) && $stable(dev_irq)));

endmodule

// File: tb/cfgp_top_bench.sv
module cfgp_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_addr = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [3:0]  dev_active;
    logic [63:0] dev_base;
    logic [31:0] dev_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cfgp_top u_cfgp_top (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .dev_active (dev_active),
        .dev_base   (dev_base),
        .dev_irq    (dev_irq)
    );

    localparam logic [63:0] BASE_DEF = 64'h0060_02F8_03F8_03F0;

    // {chk, wr, port, data[7:0], expect[7:0], req[3:0]}
    localparam int NV = 24;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 4'd2},  // R2 value port locked
        {1'b0, 1'b1, 1'b0, 8'h20, 8'h00, 4'd2},  // R2 pointer write ignored
        {1'b0, 1'b1, 1'b1, 8'h12, 8'h00, 4'd2},  // R2 value write ignored
        {1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 4'd2},  // R2 pointer locked
        {1'b0, 1'b1, 1'b0, 8'h55, 8'h00, 4'd3},  // R3 unlock
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'd3},  // R3 index still 0
        {1'b0, 1'b1, 1'b0, 8'h20, 8'h00, 4'd3},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h4D, 4'd4},  // R4 identifier
        {1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 4'd4},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h4D, 4'd4},  // R4 read-only
        {1'b0, 1'b1, 1'b0, 8'h21, 8'h00, 4'd4},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h01, 4'd4},  // R4 revision
        {1'b0, 1'b1, 1'b0, 8'h22, 8'h00, 4'd7},
        {1'b0, 1'b1, 1'b1, 8'h5A, 8'h00, 4'd7},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h5A, 4'd7},  // R7 global readback
        {1'b0, 1'b1, 1'b0, 8'h07, 8'h00, 4'd5},
        {1'b0, 1'b1, 1'b1, 8'h04, 8'h00, 4'd5},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h04, 4'd5},  // R5 selector readback
        {1'b0, 1'b1, 1'b0, 8'h22, 8'h00, 4'd7},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h5A, 4'd7},  // R7 not banked
        {1'b0, 1'b1, 1'b0, 8'h60, 8'h00, 4'd6},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h03, 4'd6},  // R6 base high, device 0x04
        {1'b0, 1'b1, 1'b0, 8'h61, 8'h00, 4'd6},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'hF8, 4'd6}   // R6 base low, device 0x04
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic port, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = port; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic port, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_addr = port;
        #1;
        check(req, {56'h0, host_rdata}, {56'h0, exp});
    endtask

    initial begin
        #1_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {60'h0, dev_active}, 64'h0);
        check("R1", dev_base, BASE_DEF);
        check("R1", {32'h0, dev_irq}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21]) wr(VEC[i][20], VEC[i][19:12]);
            else if (VEC[i][22]) rd(VEC[i][20], VEC[i][11:4], $sformatf("R%0d", VEC[i][3:0]));
        end

        // R5 banking: enable device 0x07 only
        wr(0, 8'h07); wr(1, 8'h07);
        wr(0, 8'h30); wr(1, 8'hFF);
        @(negedge clk);
        check("R5", {60'h0, dev_active}, 64'h8);
        rd(1, 8'h01, "R10");

        // R6 base and interrupt of device 0x07
        wr(0, 8'h60); wr(1, 8'h12);
        wr(0, 8'h61); wr(1, 8'h34);
        wr(0, 8'h70); wr(1, 8'h09);
        @(negedge clk);
        check("R6", dev_base, {16'h1234, BASE_DEF[47:0]});
        check("R6", {32'h0, dev_irq}, 64'h0900_0000);

        // R8 absent device and absent index
        wr(0, 8'h07); wr(1, 8'h02);
        wr(0, 8'h30); wr(1, 8'h01);
        rd(1, 8'h00, "R8");
        check("R8", {60'h0, dev_active}, 64'h8);
        wr(0, 8'h07); wr(1, 8'h07);
        wr(0, 8'h50); wr(1, 8'h77);
        rd(1, 8'h00, "R8");

        // R9 exit, then exit key while locked does nothing
        wr(0, 8'hAA);
        rd(1, 8'hFF, "R9");
        wr(1, 8'h00);
        wr(0, 8'hAA);
        rd(0, 8'hFF, "R9");
        wr(0, 8'h55);
        wr(0, 8'h60);
        rd(1, 8'h12, "R9");
        check("R2", dev_base[63:48], 64'h1234);

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1", {60'h0, dev_active}, 64'h0);
        check("R1", dev_base, BASE_DEF);
        rd(1, 8'hFF, "R1");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule